// File: doc/BRIEF.md
# Self-Voting Dual-Copy Storage Bit with Capture Window

This block stores one bit in two redundant flip-flops and drives its output from a three-input majority voter. Two voter inputs come from the two copies. The third input normally comes from a register that holds the voter's own previous output. While both copies agree they decide the output. When they disagree, the output keeps its last value.

A transient that reaches one copy's data input near the capture edge could leave the copies split, with nothing to show which copy is right. To cover this, a multiplexer feeds a clean sample of the shared data input to the third voter input for a short capture window after each capture edge. The copy that holds the correct value then wins the vote. Once the window closes, the self-vote keeps that value.

The block runs on a fast sampling clock. A one-cycle strobe marks each system-clock active edge, and the window length is counted in fast cycles. Each copy has its own powered flag, because latchup protection can switch one copy's supply off. While a copy is off, the block runs on the remaining copy. Each copy also has a flip input that models a transient on that copy's data. Cells can be chained into a shift register.

Top module: `dmr_sv_bit`

## Requirements
- R1: While rst_n is low, q_out, mismatch and cap_win are 0. After reset both copies, the data sample and the feedback register hold 0.
- R2: On a fast edge where sys_tick is 1, each powered copy i stores d_in XOR inj_flip[i]. When both copies are powered and agree, q_out equals their value.
- R3: cap_win goes to 1 on the fast edge where sys_tick is sampled 1 and stays 1 for exactly win_len fast cycles. When win_len is 0, no window opens.
- R4: While cap_win is 1, the third voter input is d_in as sampled at the last sys_tick edge. So a flip on one copy at that edge still gives q_out equal to the sampled d_in, and changes of d_in inside the window have no effect.
- R5: While cap_win is 0, the third voter input is q_out from the previous fast cycle. If both copies are powered and disagree, q_out keeps its previous value.
- R6: mismatch is 1 exactly when both pwr_ok bits are 1 and the two copies hold different values.
- R7: While pwr_ok[i] is 0, copy i holds 0 and ignores inj_flip[i]. With a window of at least one cycle, q_out then follows the remaining copy.
- R8: When pwr_ok[i] returns to 1, copy i holds 0 until its next sys_tick capture.
- R9: Four cells chained output to d_in, with copy 0 of every cell unpowered and a shared sys_tick, shift the input one stage per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sys_tick | input | 1 | One-cycle strobe marking a system-clock active edge |
| d_in | input | 1 | Shared data input |
| win_len | input | WIN_W | Capture window length in fast cycles |
| pwr_ok | input | 2 | Per-copy powered flag, 1 = powered |
| inj_flip | input | 2 | Per-copy data inversion at capture, 1 = flip |
| q_out | output | 1 | Voted output |
| mismatch | output | 1 | Both copies powered and disagreeing |
| cap_win | output | 1 | Capture window open, third voter input follows the data sample |

## Verification
The hardest state to reach is two powered copies holding different values. This never happens in normal use. The bench reaches it by pulsing inj_flip on one copy in the same cycle as sys_tick. It runs this once with a window open, where the clean data sample must win the vote, and once with win_len at 0, where only the self-vote holds the previous value. It changes d_in inside the window to show that only the sampled value counts. It also restores a copy's power without a tick, which splits the copies a second way.

// File: rtl/dmr_sv_pkg.sv
package dmr_sv_pkg;

  // Number of redundant storage copies; the voter has one more input.
  localparam int unsigned COPIES = 2;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/dmr_win_gen.sv
module dmr_win_gen #(
  parameter int unsigned WIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_tick,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_open
);

  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] cnt_d;
  logic             cnt_en;

  // Load on the capture strobe, then count down to zero.
  always_comb begin
    cnt_en = sys_tick | (cnt_q != '0);
    cnt_d  = sys_tick ? win_len : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign win_open = (cnt_q != '0);

  // R3: a non-zero length opens the window on the capture edge
  assert_win_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_tick && (win_len != '0)) |=> win_open);

  // R3: without a strobe a closed window stays closed
  assert_win_stays_shut_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_tick && !win_open) |=> !win_open);

endmodule

// File: rtl/dmr_copy_ff.sv
module dmr_copy_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_tick,
  input  logic pwr_ok,
  input  logic d_bit,
  input  logic inj,
  output logic q
);

  logic q_d;
  logic q_en;

  // An unpowered copy loses its state; a powered one captures on the strobe.
  always_comb begin
    q_en = sys_tick | !pwr_ok;
    q_d  = pwr_ok ? (d_bit ^ inj) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (q_en) begin
      q <= q_d;
    end
  end

  // R7: a switched-off copy reads zero
  assert_off_copy_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (q == 1'b0));

  // R8: a powered copy changes only on a capture strobe
  assert_copy_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !sys_tick) |=> $stable(q));

endmodule

// File: rtl/dmr_self_voter.sv
module dmr_self_voter
  import dmr_sv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sys_tick,
  input  logic win_open,
  input  logic d_in,
  input  logic q_a,
  input  logic q_b,
  output logic vote_out
);

  logic hold_q;
  logic fb_q;
  logic third;

  // Feedback multiplexer: data sample inside the window, own output outside.
  always_comb begin
    third    = win_open ? hold_q : fb_q;
    vote_out = maj3(q_a, q_b, third);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (sys_tick) begin
      hold_q <= d_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q <= 1'b0;
    end else begin
      fb_q <= vote_out;
    end
  end

  // R5: split copies outside the window keep the previous vote
  assert_self_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && (q_a != q_b)) |-> (vote_out == $past(vote_out)));

  // R4: split copies right after a capture follow the sampled data
  assert_window_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sys_tick) && win_open && (q_a != q_b)) |-> (vote_out == $past(d_in)));

endmodule

// File: rtl/dmr_sv_bit.sv
module dmr_sv_bit
  import dmr_sv_pkg::*;
#(
  parameter int unsigned WIN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_tick,
  input  logic              d_in,
  input  logic [WIN_W-1:0]  win_len,
  input  logic [COPIES-1:0] pwr_ok,
  input  logic [COPIES-1:0] inj_flip,
  output logic              q_out,
  output logic              mismatch,
  output logic              cap_win
);

  logic [COPIES-1:0] copy_q;

  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    dmr_copy_ff u_copy (
      .clk      (clk),
      .rst_n    (rst_n),
      .sys_tick (sys_tick),
      .pwr_ok   (pwr_ok[i]),
      .d_bit    (d_in),
      .inj      (inj_flip[i]),
      .q        (copy_q[i])
    );
  end

  dmr_win_gen #(.WIN_W(WIN_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_tick (sys_tick),
    .win_len  (win_len),
    .win_open (cap_win)
  );

  dmr_self_voter u_vote (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_tick (sys_tick),
    .win_open (cap_win),
    .d_in     (d_in),
    .q_a      (copy_q[0]),
    .q_b      (copy_q[1]),
    .vote_out (q_out)
  );

  assign mismatch = (&pwr_ok) & (copy_q[0] ^ copy_q[1]);

  // R2: two powered, agreeing copies decide the output
  assert_agree_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_ok == 2'b11) && (copy_q[0] == copy_q[1])) |-> (q_out == copy_q[0]));

endmodule

// File: tb/dmr_sv_bit_bench.sv
module dmr_sv_bit_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       d = 1'b0;
  logic [2:0] wl = 3'd2;
  logic [1:0] pwr = 2'b11;
  logic [1:0] inj = 2'b00;
  logic       q_out, mism, cap_win;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";
  bit    cmp_on  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmr_sv_bit #(.WIN_W(3)) u_dmr_sv_bit (
    .clk(clk), .rst_n(rst_n), .sys_tick(tick), .d_in(d), .win_len(wl),
    .pwr_ok(pwr), .inj_flip(inj), .q_out(q_out), .mismatch(mism), .cap_win(cap_win)
  );

  // Four-stage chain, copy 0 of every cell unpowered (R9)
  logic [4:0] ch_link;
  logic       ch_tick = 1'b0;
  logic       ch_in = 1'b0;
  logic [3:0] ch_mm, ch_win;
  assign ch_link[0] = ch_in;
  for (genvar k = 0; k < 4; k++) begin : g_chain
    dmr_sv_bit #(.WIN_W(3)) u_cell (
      .clk(clk), .rst_n(rst_n), .sys_tick(ch_tick), .d_in(ch_link[k]), .win_len(3'd2),
      .pwr_ok(2'b10), .inj_flip(2'b00), .q_out(ch_link[k+1]), .mismatch(ch_mm[k]),
      .cap_win(ch_win[k])
    );
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_q0, m_q1, m_hold, m_fb, m_cnt;

  function automatic int m_out();
    int third;
    third = (m_cnt > 0) ? m_hold : m_fb;
    return ((m_q0 + m_q1 + third) >= 2) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q0 = 0; m_q1 = 0; m_hold = 0; m_fb = 0; m_cnt = 0;
    end else begin
      int o;
      o = m_out();
      if (!pwr[0]) m_q0 = 0; else if (tick) m_q0 = int'(d ^ inj[0]);
      if (!pwr[1]) m_q1 = 0; else if (tick) m_q1 = int'(d ^ inj[1]);
      if (tick) m_hold = int'(d);
      m_fb  = o;
      m_cnt = tick ? int'(wl) : ((m_cnt > 0) ? m_cnt - 1 : 0);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({cur_req, " q_out vs model"}, int'(q_out), m_out());
      chk({cur_req, " mismatch vs model"}, int'(mism),
          ((pwr == 2'b11) && (m_q0 != m_q1)) ? 1 : 0);
      chk({cur_req, " cap_win vs model"}, int'(cap_win), (m_cnt > 0) ? 1 : 0);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_in(input logic dv, input logic [1:0] iv);
    @(negedge clk); d = dv; inj = iv; tick = 1'b1;
    @(negedge clk); tick = 1'b0; inj = 2'b00;
  endtask

  task automatic ch_step(input logic b);
    @(negedge clk); ch_in = b; ch_tick = 1'b1;
    @(negedge clk); ch_tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit hist[$];
    // R1: reset state
    idle(3);
    chk("R1 q_out in reset", int'(q_out), 0);
    chk("R1 mismatch in reset", int'(mism), 0);
    chk("R1 cap_win in reset", int'(cap_win), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    idle(2);
    chk("R1 q_out after reset", int'(q_out), 0);

    // R2: clean captures
    cur_req = "R2";
    tick_in(1'b1, 2'b00); idle(3); chk("R2 capture 1", int'(q_out), 1);
    tick_in(1'b0, 2'b00); idle(3); chk("R2 capture 0", int'(q_out), 0);
    tick_in(1'b1, 2'b00); idle(3); chk("R2 capture 1 again", int'(q_out), 1);
    tick_in(1'b0, 2'b00); idle(3); chk("R2 back to 0", int'(q_out), 0);

    // R4: flip on copy 0 at capture, d_in changed inside window
    cur_req = "R4";
    tick_in(1'b1, 2'b01);
    chk("R4 q_out inside window", int'(q_out), 1);
    d = 1'b0;
    idle(3);
    chk("R4 q_out after window", int'(q_out), 1);
    chk("R6 mismatch with split copies", int'(mism), 1);

    // R3: window length
    cur_req = "R3";
    wl = 3'd3;
    tick_in(1'b0, 2'b00);
    begin
      int c = 0;
      for (int i = 0; i < 6; i++) begin
        if (cap_win) c++;
        @(negedge clk);
      end
      chk("R3 window of 3 cycles", c, 3);
    end
    wl = 3'd0;
    tick_in(1'b0, 2'b00);
    chk("R3 no window for length 0", int'(cap_win), 0);
    idle(2);

    // R5: split copies with no window hold the previous value
    cur_req = "R5";
    tick_in(1'b1, 2'b10);
    idle(2);
    chk("R5 held previous value", int'(q_out), 0);
    chk("R6 mismatch flagged", int'(mism), 1);
    tick_in(1'b1, 2'b00);
    idle(1);
    chk("R2 agreeing copies drive 1", int'(q_out), 1);
    chk("R6 mismatch clear", int'(mism), 0);

    // R7: copy 0 unpowered, flips on it ignored
    cur_req = "R7";
    wl = 3'd2;
    pwr = 2'b10;
    idle(2);
    chk("R7 output kept on power loss", int'(q_out), 1);
    chk("R7 no mismatch while unpowered", int'(mism), 0);
    tick_in(1'b0, 2'b01); idle(3); chk("R7 follows remaining copy 0", int'(q_out), 0);
    tick_in(1'b1, 2'b01); idle(3); chk("R7 follows remaining copy 1", int'(q_out), 1);
    chk("R7 mismatch stays clear", int'(mism), 0);

    // R8: power returns, copy 0 holds 0 until next capture
    cur_req = "R8";
    pwr = 2'b11;
    idle(2);
    chk("R8 restored copy reads 0", int'(mism), 1);
    chk("R8 output held", int'(q_out), 1);
    tick_in(1'b1, 2'b00); idle(2);
    chk("R8 recaptured copy agrees", int'(mism), 0);
    chk("R8 output after recapture", int'(q_out), 1);

    // R9: shift chain with one copy per cell unpowered
    cur_req = "R9";
    hist = '{0, 0, 0, 0};
    foreach (ch_mm[k]) chk("R9 chain reset state", int'(ch_link[k+1]), 0);
    for (int s = 0; s < 12; s++) begin
      bit b;
      b = (s < 8) ? ((8'b0100_1101 >> s) & 1'b1) : 1'b0;
      ch_step(b);
      hist.push_front(b);
      void'(hist.pop_back());
      idle(3);
      for (int k = 0; k < 4; k++)
        chk($sformatf("R9 stage %0d step %0d", k, s), int'(ch_link[k+1]), int'(hist[k]));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule